// File: doc/BRIEF.md
# Snapshot Integration Timing Controller

This block sequences the frame-level control strobes of a snapshot-integrating imager readout. It produces four strobes from a frame sync input, a line sync input and the pixel clock: an integrator reset, an integrate enable, a one-cycle sample-and-hold transfer and a readout window. All pixels share these strobes, so they integrate at the same time and their results move to per-pixel hold storage together. Durations are counted in clock cycles. The block contains no analog behaviour.

A single frame sync pulse sets both the integration window and the operating mode. The mode is latched from `itrReq` when frame sync falls.

- In overlapped mode (`itrReq` low), integration starts after the fall and lasts until the next rising edge. At that edge the frame is transferred. Readout of that frame then runs while the next frame integrates.
- In sequential mode (`itrReq` high), integration also starts after the fall. It lasts as many cycles as frame sync was sampled high. Transfer and readout follow, so one frame takes roughly integration time plus readout time.
- A short-exposure request lowers the minimum integration length, but only in sequential mode.

An integration that is too short raises a one-cycle error pulse.

Top module: `snap_int_timer`

## Requirements
- R1: A high `masterRst` sampled at a clock edge leaves every strobe low, the readout window closed, `intErr` low and overlapped mode selected (`modeItr` = 0) from that edge on. There is no other reset.
- R2: The clock edge that first samples `frameSync` low after high latches `itrReq` into `modeItr`. It also raises `intReset` for exactly one cycle, and `intEnable` rises at the following edge.
- R3: In sequential mode, `intEnable` stays high for exactly W cycles. W is the number of clock edges at which `frameSync` was sampled high during the pulse, saturating at 2^CNT_W-1.
- R4: In overlapped mode, integration continues until the first edge that samples `frameSync` high after low. At that edge `intEnable` drops and `shTransfer` rises.
- R5: `shTransfer` is high for exactly one cycle, directly after the last `intEnable` cycle. `readActive` rises at the next edge.
- R6: `readActive` closes at the edge that detects the NUM_LINES-th falling edge of `lineSync` counted since it opened. Line sync falls while the window is closed change nothing.
- R7: In sequential mode, `intErr` pulses for one cycle, together with `intReset`, when W is below MIN_INT_CYC. When `shortReq` is high at the fall, the limit is MIN_SHORT_CYC instead.
- R8: In overlapped mode, `intErr` pulses for one cycle, together with `shTransfer`, when fewer than MIN_INT_CYC integration cycles have elapsed. `shortReq` has no effect on this limit.
- R9: A rising edge of `frameSync` while no integration is in progress produces no transfer and does not open the readout window.
- R10: At most one of `intReset`, `intEnable` and `shTransfer` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock; all inputs sampled on its rising edge |
| masterRst | input | 1 | Synchronous master reset, active high |
| frameSync | input | 1 | Frame sync; rise starts a frame, fall sets mode and window |
| lineSync | input | 1 | Line sync; each fall ends one readout line |
| itrReq | input | 1 | Mode request latched at the frame sync fall: 1 = sequential |
| shortReq | input | 1 | Short-exposure request latched at the fall (sequential only) |
| intReset | output | 1 | One-cycle integrator reset before integration |
| intEnable | output | 1 | Integration active |
| shTransfer | output | 1 | One-cycle sample-and-hold transfer |
| readActive | output | 1 | Readout window open |
| modeItr | output | 1 | Latched mode: 1 = sequential, 0 = overlapped |
| intErr | output | 1 | One-cycle pulse when an integration was shorter than allowed |

## Verification
Every strobe is registered once. As a result:

- `intReset`, `modeItr` and the sequential-mode error appear in the cycle right after the edge that detects the frame sync fall.
- `intEnable` appears one cycle later than that.
- `shTransfer` and the overlapped-mode error appear in the cycle after the terminating edge.
- `readActive` opens one cycle after the transfer, and closes in the cycle after the edge that sees the last counted line sync fall.

The driver derives each of these cycle numbers from the cycle in which it moved the input, and queues a full expected output vector tagged with that cycle. The monitor compares only at the tagged cycle, half a period away from the active edge, and reports any queued item whose cycle has already passed.

// File: rtl/snap_pkg.sv
package snap_pkg;

  // strobes from the sequencer to the counter datapath
  typedef struct packed {
    logic clearHi;    // frame sync rose: restart high-width count at one
    logic incHi;      // frame sync still high: extend high-width count
    logic loadLen;    // frame sync fell: freeze high width as target length
    logic startInt;   // first integration cycle follows
    logic incInt;     // integration cycle in progress
    logic clearLine;  // readout window opens
    logic incLine;    // a line ended inside the window
  } dpCtrl_t;

  // comparison results from the datapath back to the sequencer
  typedef struct packed {
    logic hiBelowNorm;
    logic hiBelowShort;
    logic intBelowNorm;
    logic intDone;
    logic lineLast;
  } dpFlag_t;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_RESET = 2'd1,
    PH_INTEG = 2'd2,
    PH_XFER  = 2'd3
  } phase_t;

endpackage

// File: rtl/snap_dp.sv
module snap_dp
  import snap_pkg::*;
#(
  parameter int CNT_W         = 16,
  parameter int NUM_LINES     = 256,
  parameter int MIN_INT_CYC   = 1000,
  parameter int MIN_SHORT_CYC = 100,
  parameter int LINE_W        = 9
) (
  input  logic    clk,
  input  logic    masterRst,
  input  dpCtrl_t ctl,
  input  logic    modeItr,
  input  logic    readActive,
  output dpFlag_t flags
);

  localparam logic [CNT_W-1:0]  CNT_MAX   = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0]  LIM_NORM  = CNT_W'(MIN_INT_CYC);
  localparam logic [CNT_W-1:0]  LIM_SHORT = CNT_W'(MIN_SHORT_CYC);
  localparam logic [LINE_W-1:0] LINE_END  = LINE_W'(NUM_LINES - 1);

  logic [CNT_W-1:0]  hiCnt;
  logic [CNT_W-1:0]  intLen;
  logic [CNT_W-1:0]  intCnt;
  logic [LINE_W-1:0] lineCnt;

  always_ff @(posedge clk) begin
    if (masterRst) begin
      hiCnt   <= '0;
      intLen  <= '0;
      intCnt  <= '0;
      lineCnt <= '0;
    end else begin
      if (ctl.clearHi)
        hiCnt <= CNT_W'(1);
      else if (ctl.incHi && hiCnt != CNT_MAX)
        hiCnt <= hiCnt + CNT_W'(1);

      if (ctl.loadLen)
        intLen <= hiCnt;

      if (ctl.startInt)
        intCnt <= CNT_W'(1);
      else if (ctl.incInt && intCnt != CNT_MAX)
        intCnt <= intCnt + CNT_W'(1);

      if (ctl.clearLine)
        lineCnt <= '0;
      else if (ctl.incLine)
        lineCnt <= lineCnt + LINE_W'(1);
    end
  end

  always_comb begin
    flags.hiBelowNorm  = hiCnt < LIM_NORM;
    flags.hiBelowShort = hiCnt < LIM_SHORT;
    flags.intBelowNorm = intCnt < LIM_NORM;
    flags.intDone      = intCnt == intLen;
    flags.lineLast     = lineCnt == LINE_END;
  end

  AST_ITR_WITHIN_LEN: assert property (@(posedge clk) disable iff (masterRst)
    (modeItr && ctl.incInt) |-> (intCnt <= intLen)); // R3

  AST_LINE_BOUND: assert property (@(posedge clk) disable iff (masterRst)
    readActive |-> (lineCnt < LINE_W'(NUM_LINES))); // R6

endmodule

// File: rtl/snap_ctrl.sv
module snap_ctrl
  import snap_pkg::*;
(
  input  logic    clk,
  input  logic    masterRst,
  input  logic    frameSync,
  input  logic    lineSync,
  input  logic    itrReq,
  input  logic    shortReq,
  input  dpFlag_t flags,
  output dpCtrl_t ctl,
  output logic    intReset,
  output logic    intEnable,
  output logic    shTransfer,
  output logic    readActive,
  output logic    modeItr,
  output logic    intErr
);

  phase_t phase;
  logic   fsQ;
  logic   lsQ;
  logic   fsRise;
  logic   fsFall;
  logic   lsFall;
  logic   tooShort;

  assign fsRise = frameSync & ~fsQ;
  assign fsFall = ~frameSync & fsQ;
  assign lsFall = ~lineSync & lsQ;
  assign tooShort = itrReq & (shortReq ? flags.hiBelowShort : flags.hiBelowNorm);

  assign intReset   = phase == PH_RESET;
  assign intEnable  = phase == PH_INTEG;
  assign shTransfer = phase == PH_XFER;

  always_comb begin
    ctl.clearHi   = fsRise;
    ctl.incHi     = frameSync & fsQ;
    ctl.loadLen   = fsFall;
    ctl.startInt  = (phase == PH_RESET) & ~fsFall;
    ctl.incInt    = phase == PH_INTEG;
    ctl.clearLine = phase == PH_XFER;
    ctl.incLine   = readActive & lsFall & ~flags.lineLast & (phase != PH_XFER);
  end

  always_ff @(posedge clk) begin
    if (masterRst) begin
      phase      <= PH_IDLE;
      fsQ        <= 1'b0;
      lsQ        <= 1'b0;
      readActive <= 1'b0;
      modeItr    <= 1'b0;
      intErr     <= 1'b0;
    end else begin
      fsQ    <= frameSync;
      lsQ    <= lineSync;
      intErr <= 1'b0;

      if (fsFall) begin
        phase   <= PH_RESET;
        modeItr <= itrReq;
        intErr  <= tooShort;
      end else begin
        unique case (phase)
          PH_IDLE:  phase <= PH_IDLE;
          PH_RESET: phase <= PH_INTEG;
          PH_INTEG: begin
            if (!modeItr && fsRise) begin
              phase  <= PH_XFER;
              intErr <= flags.intBelowNorm;
            end else if (modeItr && flags.intDone) begin
              phase <= PH_XFER;
            end
          end
          PH_XFER:  phase <= PH_IDLE;
        endcase
      end

      if (phase == PH_XFER)
        readActive <= 1'b1;
      else if (readActive && lsFall && flags.lineLast)
        readActive <= 1'b0;
    end
  end

  AST_RESET_IDLE: assert property (@(posedge clk)
    masterRst |=> (!intEnable && !shTransfer && !readActive && !modeItr && !intErr)); // R1

  AST_RST_THEN_INT: assert property (@(posedge clk) disable iff (masterRst)
    intReset |=> intEnable); // R2

  AST_XFER_SINGLE: assert property (@(posedge clk) disable iff (masterRst)
    shTransfer |=> (!shTransfer && readActive)); // R5

  AST_XFER_FROM_INT: assert property (@(posedge clk) disable iff (masterRst)
    $rose(shTransfer) |-> $past(intEnable)); // R5

  AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (masterRst)
    intErr |=> !intErr); // R7

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (masterRst)
    $onehot0({intReset, intEnable, shTransfer})); // R10

endmodule

// File: rtl/snap_int_timer.sv
module snap_int_timer
  import snap_pkg::*;
#(
  parameter int CNT_W         = 16,
  parameter int NUM_LINES     = 256,
  parameter int MIN_INT_CYC   = 1000,
  parameter int MIN_SHORT_CYC = 100
) (
  input  logic clk,
  input  logic masterRst,
  input  logic frameSync,
  input  logic lineSync,
  input  logic itrReq,
  input  logic shortReq,
  output logic intReset,
  output logic intEnable,
  output logic shTransfer,
  output logic readActive,
  output logic modeItr,
  output logic intErr
);

  localparam int LINE_W = $clog2(NUM_LINES + 1);

  dpCtrl_t ctl;
  dpFlag_t flags;

  snap_ctrl i_ctrl (
    .clk        (clk),
    .masterRst  (masterRst),
    .frameSync  (frameSync),
    .lineSync   (lineSync),
    .itrReq     (itrReq),
    .shortReq   (shortReq),
    .flags      (flags),
    .ctl        (ctl),
    .intReset   (intReset),
    .intEnable  (intEnable),
    .shTransfer (shTransfer),
    .readActive (readActive),
    .modeItr    (modeItr),
    .intErr     (intErr)
  );

  snap_dp #(
    .CNT_W         (CNT_W),
    .NUM_LINES     (NUM_LINES),
    .MIN_INT_CYC   (MIN_INT_CYC),
    .MIN_SHORT_CYC (MIN_SHORT_CYC),
    .LINE_W        (LINE_W)
  ) i_dp (
    .clk        (clk),
    .masterRst  (masterRst),
    .ctl        (ctl),
    .modeItr    (modeItr),
    .readActive (readActive),
    .flags      (flags)
  );

endmodule

// File: tb/test_snap_int_timer.sv
`timescale 1ns/1ps
module test_snap_int_timer;

  localparam int NL   = 4;
  localparam int MINN = 20;
  localparam int MINS = 5;

  logic clk = 1'b0;
  logic masterRst = 1'b1;
  logic frameSync = 1'b0;
  logic lineSync = 1'b0;
  logic itrReq = 1'b0;
  logic shortReq = 1'b0;
  logic intReset, intEnable, shTransfer, readActive, modeItr, intErr;

  snap_int_timer #(
    .CNT_W(12), .NUM_LINES(NL), .MIN_INT_CYC(MINN), .MIN_SHORT_CYC(MINS)
  ) i_snap_int_timer (
    .clk(clk), .masterRst(masterRst), .frameSync(frameSync), .lineSync(lineSync),
    .itrReq(itrReq), .shortReq(shortReq), .intReset(intReset), .intEnable(intEnable),
    .shTransfer(shTransfer), .readActive(readActive), .modeItr(modeItr), .intErr(intErr)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int         at;
    logic [5:0] v;
    string      req;
  } exp_t;

  exp_t q[$];
  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  // scoreboard vector order: {modeItr, intErr, readActive, shTransfer, intEnable, intReset}
  logic expMode = 1'b0;
  logic expRead = 1'b0;
  logic expEn = 1'b0;
  int intStart = 0;

  function automatic logic [5:0] mk(logic m, logic e, logic r, logic s, logic n, logic t);
    return {m, e, r, s, n, t};
  endfunction

  task automatic push(int at, logic [5:0] v, string req);
    exp_t e;
    e.at = at; e.v = v; e.req = req;
    q.push_back(e);
  endtask

  // monitor: compares at the predicted cycle, away from the active edge
  always @(negedge clk) begin
    exp_t e;
    logic [5:0] obs;
    obs = {modeItr, intErr, readActive, shTransfer, intEnable, intReset};
    if (!masterRst) begin
      nChecks++;
      if ($countones({intReset, intEnable, shTransfer}) > 1) begin
        nFail++;
        $display("FAIL R10 cycle %0d: strobes %b expected at most one high", cyc,
                 {intReset, intEnable, shTransfer});
      end
    end
    while (q.size() > 0 && q[0].at <= cyc) begin
      e = q.pop_front();
      nChecks++;
      if (e.at != cyc || obs !== e.v) begin
        nFail++;
        $display("FAIL %s cycle %0d (due %0d): got %b expected %b", e.req, cyc, e.at, obs, e.v);
      end
    end
  end

  task automatic waitCyc(int t);
    while (cyc < t) @(negedge clk);
  endtask

  // raises frame sync now (at a falling clock edge), holds it hiLen cycles, lowers it
  task automatic fsHigh(int hiLen, bit itr, bit sh, output int k);
    itrReq = itr;
    shortReq = sh;
    frameSync = 1'b1;
    repeat (hiLen) @(negedge clk);
    frameSync = 1'b0;
    k = cyc + 1;
  endtask

  task automatic lines(int n);
    int b;
    logic wasRead;
    wasRead = expRead;
    for (int i = 0; i < n; i++) begin
      lineSync = 1'b1;
      repeat (2) @(negedge clk);
      lineSync = 1'b0;
      b = cyc;
      // R6: window stays open until the last counted line fall
      push(b + 1, mk(expMode, 1'b0, wasRead && (i < n - 1), 1'b0, expEn, 1'b0), "R6");
      repeat (2) @(negedge clk);
    end
    expRead = 1'b0;
  endtask

  task automatic iwrFallChecks(int k);
    expMode = 1'b0;
    push(k, mk(1'b0, 1'b0, expRead, 1'b0, 1'b0, 1'b1), "R2");
    push(k + 1, mk(1'b0, 1'b0, expRead, 1'b0, 1'b1, 1'b0), "R2");
    expEn = 1'b1;
    intStart = k + 1;
  endtask

  // overlapped mode: end current integration after intCycles, start the next frame
  task automatic iwrRise(int intCycles, int hiLen, bit sh);
    int m;
    int k;
    m = intStart + intCycles;
    waitCyc(m - 1);
    push(m, mk(1'b0, intCycles < MINN, expRead, 1'b1, 1'b0, 1'b0), "R4_R8");
    push(m + 1, mk(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0), "R5");
    expRead = 1'b1;
    expEn = 1'b0;
    fsHigh(hiLen, 1'b0, sh, k);
    iwrFallChecks(k);
    waitCyc(k + 1);
  endtask

  // sequential mode frame with high width w
  task automatic itrFrame(int w, bit sh, bit expErr);
    int k;
    fsHigh(w, 1'b1, sh, k);
    push(k, mk(1'b1, expErr, 1'b0, 1'b0, 1'b0, 1'b1), "R7");
    push(k + 1, mk(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0), "R2");
    push(k + w, mk(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0), "R3");
    push(k + w + 1, mk(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0), "R3");
    push(k + w + 2, mk(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0), "R5");
    expMode = 1'b1;
    expEn = 1'b0;
    expRead = 1'b1;
    waitCyc(k + w + 2);
    lines(NL);
  endtask

  initial begin
    int k;
    repeat (3) @(negedge clk);
    masterRst = 1'b0;
    push(cyc + 1, 6'b0, "R1");

    repeat (2) @(negedge clk);
    // R9: a rise with no integration running yields nothing
    push(cyc + 1, 6'b0, "R9");
    push(cyc + 2, 6'b0, "R9");
    fsHigh(3, 1'b0, 1'b0, k);
    iwrFallChecks(k);
    waitCyc(k + 1);

    lines(2);                     // R6: falls outside the window are ignored
    iwrRise(25, 3, 1'b0);         // R4 no error
    iwrRise(10, 3, 1'b1);         // R8 error, short request has no effect
    lines(NL);                    // R6 close window
    iwrRise(MINN, 3, 1'b0);       // R8 boundary: exactly the minimum
    lines(NL);

    // R1: master reset in the middle of an integration
    masterRst = 1'b1;
    push(cyc + 1, 6'b0, "R1");
    @(negedge clk);
    masterRst = 1'b0;
    push(cyc + 1, 6'b0, "R1");
    expMode = 1'b0; expEn = 1'b0; expRead = 1'b0;
    repeat (3) @(negedge clk);

    itrFrame(25, 1'b0, 1'b0);     // R3 long frame
    itrFrame(10, 1'b0, 1'b1);     // R7 below normal minimum
    itrFrame(MINN, 1'b0, 1'b0);   // R7 boundary
    itrFrame(MINN - 1, 1'b0, 1'b1);
    itrFrame(6, 1'b1, 1'b0);      // R7 short limit
    itrFrame(MINS, 1'b1, 1'b0);
    itrFrame(MINS - 1, 1'b1, 1'b1);
    itrFrame(1, 1'b1, 1'b1);      // R3 single-cycle integration

    repeat (5) @(negedge clk);
    if (q.size() != 0) begin
      nFail++;
      $display("FAIL pending %0d items, expected 0", q.size());
    end
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

endmodule